// File: doc/BRIEF.md
# Burst-Framed Serial Transmitter

This block sends a fixed-length burst of words as one continuous serial stream. It makes its own bit clock by dividing the system clock. A single frame-sync pulse opens each burst. The burst length is set by two parameters: the number of words and the word width. By default a burst is ten 32-bit words, which is 320 data bits with no idle bit between words.

Words are loaded through a valid/ready write port into a small buffer that holds exactly one burst. Once the buffer is full, a start strobe launches the burst. The frame sync is high for the first bit slot. The first data bit follows one bit slot later, and each word is sent most significant bit first. After the final bit the block raises a one-cycle done pulse and stops the bit clock. It then holds frame sync and data low until the buffer has been refilled and started again. Nothing repeats on its own, so bursts may be launched at any irregular interval.

Top module: `burst_tx`

## Requirements
- R1: After a synchronous active-high reset, `bclk`, `fsync`, `sdata`, `busy` and `done` are low and `in_ready` is high.
- R2: `in_ready` is high only while the block is idle and the buffer holds fewer than N_WORDS words. A word is stored on a clock edge where `in_valid` and `in_ready` are both high. A write offered while `in_ready` is low is dropped.
- R3: A start is accepted only when the block is idle and the buffer holds N_WORDS words. Otherwise `start` has no effect: `busy` and `fsync` stay low.
- R4: During a burst, each bit slot lasts CLK_DIV system cycles, and `bclk` is high for the first CLK_DIV/2 cycles of each slot. `bclk` is low whenever `busy` is low.
- R5: `busy` and `fsync` rise in the system cycle after the clock edge that accepts the start. `fsync` stays high for exactly one bit slot (CLK_DIV cycles) and is not raised again during the burst.
- R6: Slot k (k = 1 .. N_WORDS*WORD_W) carries data bit k-1 of the burst. Words go out in write order, each most significant bit first. There are no gaps, so consecutive words are exactly WORD_W slots apart, and `sdata` is low during the sync slot.
- R7: Outside a burst, `fsync` and `sdata` stay low. No new frame sync appears until a fresh start is accepted, and the buffer is empty after a burst.
- R8: `done` is high for exactly one system cycle. That cycle immediately follows the last data slot, and in it `busy` has just fallen.
- R9: A start strobe or a write offered during a burst changes neither the stream nor the burst timing.
- R10: A reset asserted mid-burst stops the burst, forces all outputs low and empties the buffer, so a later start without new writes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write port: word offered |
| in_ready | output | 1 | Write port: buffer can accept a word |
| in_data | input | WORD_W | Write port: word value |
| start | input | 1 | Launch request for a burst |
| busy | output | 1 | High for the whole burst |
| done | output | 1 | One-cycle pulse at burst end |
| bclk | output | 1 | Generated serial bit clock |
| fsync | output | 1 | Frame sync, one bit slot per burst |
| sdata | output | 1 | Serial data, changes on rising `bclk` |

## Verification
The bench's key target is the boundary between words. A design that inserts an extra slot there, like the per-word framing this block replaces, misplaces every later bit and lengthens the burst by one slot per word. It also checks that an incomplete buffer blocks a start. Without that check, a design would send stale or zero words.

Further checks cover the end of the burst. A design that re-arms the sync, or keeps the divider running, would show a second `fsync` or a free-running `bclk` in the idle cycles. Starts and writes offered mid-burst, and a reset during a burst, are also applied. A design that leaks either would emit a second sync, shift the stream, or restart from a stale buffer.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;
    localparam int unsigned DEF_WORD_W  = 32;
    localparam int unsigned DEF_N_WORDS = 10;
    localparam int unsigned DEF_CLK_DIV = 4;
endpackage

// File: rtl/burst_tx_divider.sv
module burst_tx_divider #(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick,
    output logic bclk
);
    localparam int unsigned CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(CLK_DIV / 2);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (en && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == LAST);
    assign bclk = en && (cnt_q < HALF);
endmodule

// File: rtl/burst_tx_buffer.sv
module burst_tx_buffer #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DEPTH  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              full
);
    localparam int unsigned PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
    } buf_t;

    buf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.mem[s_q.wp] = wr_data;
            s_d.wp = (s_q.wp == PTR_LAST) ? '0 : s_q.wp + 1'b1;
        end
        if (rd_en) begin
            s_d.rp = (s_q.rp == PTR_LAST) ? '0 : s_q.rp + 1'b1;
        end
        case ({wr_en, rd_en})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rd_data = s_q.mem[s_q.rp];
    assign full    = (s_q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/burst_tx.sv
module burst_tx #(
    parameter int unsigned WORD_W  = burst_tx_pkg::DEF_WORD_W,
    parameter int unsigned N_WORDS = burst_tx_pkg::DEF_N_WORDS,
    parameter int unsigned CLK_DIV = burst_tx_pkg::DEF_CLK_DIV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              bclk,
    output logic              fsync,
    output logic              sdata
);
    localparam int unsigned BIT_W  = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam int unsigned WCNT_W = (N_WORDS > 2) ? $clog2(N_WORDS) : 1;
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WORD_W - 1);
    localparam logic [WCNT_W-1:0] WORD_LAST = WCNT_W'(N_WORDS - 1);

    typedef struct packed {
        logic              busy;
        logic              sync_slot;
        logic [WORD_W-1:0] shreg;
        logic [BIT_W-1:0]  bit_idx;
        logic [WCNT_W-1:0] word_idx;
        logic              sdata;
        logic              fsync;
        logic              done;
    } ser_t;

    ser_t s_d, s_q;

    logic              tick;
    logic              buf_full;
    logic              pop;
    logic [WORD_W-1:0] head;
    logic              push;

    burst_tx_divider #(.CLK_DIV(CLK_DIV)) div_i (
        .clk  (clk),
        .rst  (rst),
        .en   (s_q.busy),
        .tick (tick),
        .bclk (bclk)
    );

    burst_tx_buffer #(.WORD_W(WORD_W), .DEPTH(N_WORDS)) buf_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push),
        .wr_data (in_data),
        .rd_en   (pop),
        .rd_data (head),
        .full    (buf_full)
    );

    assign in_ready = !s_q.busy && !buf_full;
    assign push     = in_valid && in_ready;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        pop      = 1'b0;
        if (!s_q.busy) begin
            if (start && buf_full) begin
                s_d.busy      = 1'b1;
                s_d.sync_slot = 1'b1;
                s_d.fsync     = 1'b1;
                s_d.sdata     = 1'b0;
                s_d.bit_idx   = '0;
                s_d.word_idx  = '0;
            end
        end else if (tick) begin
            s_d.fsync = 1'b0;
            if (s_q.sync_slot || s_q.bit_idx == BIT_LAST) begin
                if (!s_q.sync_slot && s_q.word_idx == WORD_LAST) begin
                    s_d.busy  = 1'b0;
                    s_d.done  = 1'b1;
                    s_d.sdata = 1'b0;
                end else begin
                    pop           = 1'b1;
                    s_d.sdata     = head[WORD_W-1];
                    s_d.shreg     = head << 1;
                    s_d.bit_idx   = '0;
                    s_d.word_idx  = s_q.sync_slot ? '0 : s_q.word_idx + 1'b1;
                    s_d.sync_slot = 1'b0;
                end
            end else begin
                s_d.sdata   = s_q.shreg[WORD_W-1];
                s_d.shreg   = s_q.shreg << 1;
                s_d.bit_idx = s_q.bit_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign busy  = s_q.busy;
    assign done  = s_q.done;
    assign fsync = s_q.fsync;
    assign sdata = s_q.sdata;
endmodule

// File: rtl/burst_tx_chk.sv
module burst_tx_chk #(
    parameter int unsigned CLK_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic start,
    input logic busy,
    input logic done,
    input logic bclk,
    input logic fsync,
    input logic sdata
);
    localparam int unsigned FC_W = $clog2(CLK_DIV + 2);

    logic [FC_W-1:0] fs_cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        fs_cnt_q <= '0;
        else if (fsync) fs_cnt_q <= fs_cnt_q + 1'b1;
        else            fs_cnt_q <= '0;
    end

    // R2: no write accepted while a burst runs
    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    // R4 / R7: quiet lines outside a burst
    assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bclk && !fsync && !sdata));

    // R5: a sync appears only right after an accepted start
    assert_sync_after_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync) |-> ($past(start) && !$past(busy) && busy));

    // R5: sync width bounded by one bit slot
    assert_sync_width_R5: assert property (@(posedge clk) disable iff (rst)
        fsync |-> (fs_cnt_q < FC_W'(CLK_DIV)));

    // R8: done marks the fall of busy
    assert_done_edge_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8: single-cycle pulse
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind burst_tx burst_tx_chk #(.CLK_DIV(CLK_DIV)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .bclk     (bclk),
    .fsync    (fsync),
    .sdata    (sdata)
);

// File: tb/burst_tx_tb_top.sv
`timescale 1ns/1ps
module burst_tx_tb_top;
    localparam int W     = 32;
    localparam int N     = 10;
    localparam int DIV   = 4;
    localparam int SLOTS = N * W + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         start = 1'b0;
    logic         busy, done, bclk, fsync, sdata;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] words [N];

    always #4 clk = ~clk;

    burst_tx #(.WORD_W(W), .N_WORDS(N), .CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .start(start), .busy(busy), .done(done),
        .bclk(bclk), .fsync(fsync), .sdata(sdata)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] pat(input int p, input int i);
        case (p)
            0:       return {W{1'b1}};
            1:       return '0;
            2:       return 32'hA5A5_0000 ^ W'(i);
            default: return W'((i + 1) * 32'h9E37_79B9);
        endcase
    endfunction

    task automatic idle_chk(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk(req, "busy", busy, 0);
            chk(req, "fsync", fsync, 0);
            chk(req, "sdata", sdata, 0);
            chk(req, "bclk", bclk, 0);
            chk(req, "done", done, 0);
        end
    endtask

    task automatic load(input int p, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            words[i] = pat(p, i);
            chk("R2", "in_ready before write", in_ready, 1);
            in_valid = 1'b1;
            in_data  = words[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_burst(input bit disturb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < SLOTS * DIV; t++) begin
            int slot = t / DIV;
            int ph   = t % DIV;
            int eb;
            eb = (slot == 0) ? 0 : int'(words[(slot - 1) / W][W - 1 - ((slot - 1) % W)]);
            chk("R4", "bclk", bclk, (ph < DIV / 2) ? 1 : 0);
            chk("R5", "fsync", fsync, (slot == 0) ? 1 : 0);
            chk("R6", "sdata", sdata, eb);
            chk("R5", "busy", busy, 1);
            chk("R8", "done early", done, 0);
            chk("R2", "in_ready in burst", in_ready, 0);
            if (disturb && t == 40) begin   // R9: start and write mid-burst
                start    = 1'b1;
                in_valid = 1'b1;
                in_data  = 32'hDEAD_BEEF;
            end
            if (disturb && t == 42) begin
                start    = 1'b0;
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk("R8", "done pulse", done, 1);
        chk("R8", "busy fall", busy, 0);
        chk("R7", "fsync end", fsync, 0);
        chk("R7", "sdata end", sdata, 0);
        chk("R7", "buffer empty", in_ready, 1);
        idle_chk("R7", 12);
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "fsync", fsync, 0);
        chk("R1", "sdata", sdata, 0);
        chk("R1", "bclk", bclk, 0);
        chk("R1", "in_ready", in_ready, 1);

        // R3: start with one word missing is ignored
        load(2, N - 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3", "busy partial", busy, 0);
        idle_chk("R3", 10);
        chk("R2", "ready partial", in_ready, 1);
        in_valid = 1'b1;
        words[N-1] = pat(2, N - 1);
        in_data = words[N-1];
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "ready when full", in_ready, 0);
        // R2: write offered to a full buffer is dropped
        in_valid = 1'b1;
        in_data  = 32'h1234_5678;
        @(negedge clk);
        in_valid = 1'b0;
        run_burst(1'b0);

        for (int p = 0; p < 4; p++) begin
            idle_chk("R7", p * 7 + 3);    // irregular gaps between bursts
            load(p, N);
            chk("R2", "ready when full", in_ready, 0);
            run_burst(p == 3);
        end

        // R10: reset during a burst
        load(3, N);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10", "busy", busy, 0);
        chk("R10", "fsync", fsync, 0);
        chk("R10", "bclk", bclk, 0);
        chk("R10", "in_ready", in_ready, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idle_chk("R10", 10);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule